// File: doc/BRIEF.md
# Wavefront Dispatcher with SIMD Slot Placement

The block accepts one work request at a time from a command front end: a program start address and a thread count. It cuts the request into wavefronts of a fixed lane width (64 by default), rounding the thread count up to whole wavefronts. In the last wavefront, the lanes beyond the requested count are switched off through a lane-valid mask. Each wavefront goes to one of several SIMD units (4 by default), and each SIMD unit has a fixed number of wavefront slots (10 by default). The wavefront stays on that SIMD unit until the unit reports that it has retired.

One launch record is issued per clock at most. The record carries the chosen SIMD, the program start address to load as that slot's instruction pointer, the wavefront's index within the request, and its lane mask. Placement picks the SIMD unit with the most free slots. When every slot is occupied, launching stops until a retirement frees a slot. The block counts the wavefronts that are still outstanding. Once all wavefronts of the request have been launched and retired, it raises a one-cycle done pulse and becomes ready for the next request.

Top module: `wave_dispatch`

## Requirements
- R1: After reset `req_ready` is 1, and `launch_valid` and `done` are 0. `req_ready` is 1 exactly while no request is being processed. A request is taken in the cycle where `req_valid` and `req_ready` are both 1.
- R2: A request for N threads (N > 0) produces ceil(N/LANES) launch records, one per cycle at most. Their `launch_wave` values are 0, 1, 2, … in increasing order.
- R3: Bit b of `launch_mask` enables lane b. Every wavefront except the last has all LANES bits set. The last wavefront has the low (N mod LANES) bits set, or all bits set when N mod LANES is 0.
- R4: Every launch record of a request carries that request's `req_pc` in `launch_pc`.
- R5: Each wavefront goes to the SIMD index with the most free slots. When several indices tie, the lowest index wins.
- R6: While all NUM_SIMD×SLOTS slots are occupied, `launch_valid` stays 0 and the remaining wavefronts are held. Launching resumes after a retirement.
- R7: `done` is a pulse of exactly one cycle. It is raised only after every wavefront of the request has been launched and retired, and it is raised once per request.
- R8: A request with a thread count of zero launches nothing. `done` is 1 in the second cycle after acceptance, and `req_ready` is 1 again in that cycle.
- R9: A `req_valid` presented while a request is in progress has no effect on the current request's launch records.
- R10: A pulse of `retire_valid` with `retire_simd` = k frees one slot on SIMD k. The next launch can then use that SIMD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Work request present |
| req_ready | output | 1 | Dispatcher idle and able to take a request |
| req_pc | input | PC_W | Program start address of the request |
| req_threads | input | TC_W | Requested thread count |
| launch_valid | output | 1 | Launch record valid this cycle |
| launch_simd | output | SEL_W | SIMD unit receiving the wavefront |
| launch_pc | output | PC_W | Instruction pointer for the slot |
| launch_wave | output | WID_W | Wavefront index within the request |
| launch_mask | output | LANES | Lane-valid mask |
| retire_valid | input | 1 | A wavefront has finished |
| retire_simd | input | SEL_W | SIMD unit of the finished wavefront |
| done | output | 1 | One-cycle completion pulse for the request |

## Verification
The bench builds the block with LANES = 64 and NUM_SIMD = 4, but with only 2 slots per SIMD and a 12-bit thread count. With only eight slots, a single 600-thread request of ten wavefronts fills every slot, stalls, and then resumes on exactly the SIMD that a retirement freed. This exercises the back-pressure path and the placement rule together. Lane-exact masks are checked for partial tails (32 and 24 lanes) and for an exact multiple of 64. A zero-thread request is also checked, and so is a request presented while the block is busy.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [0:0] {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;

  // Wavefronts needed for a thread count: ceil(thr / 2**lane_bits).
  function automatic logic [31:0] waves_for(input logic [31:0] thr,
                                            input int unsigned lane_bits);
    logic [31:0] low_mask;
    low_mask = (32'd1 << lane_bits) - 32'd1;
    return (thr >> lane_bits) + (((thr & low_mask) != 32'd0) ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/wd_slot_ledger.sv
module wd_slot_ledger #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 10,
  parameter int CNT_W    = 4,
  parameter int SEL_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_valid,
  input  logic [SEL_W-1:0]               alloc_sel,
  input  logic                           release_valid,
  input  logic [SEL_W-1:0]               release_sel,
  output logic [NUM_SIMD-1:0][CNT_W-1:0] free_cnt
);

  for (genvar g = 0; g < NUM_SIMD; g++) begin : g_simd
    logic [CNT_W-1:0] used_q;
    logic             take;
    logic             give;

    assign take = alloc_valid   && (alloc_sel   == SEL_W'(g));
    assign give = release_valid && (release_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) used_q <= '0;
      else        used_q <= used_q + CNT_W'(take) - CNT_W'(give);
    end

    assign free_cnt[g] = CNT_W'(SLOTS) - used_q;

    // R6: a launch never lands on a full SIMD
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (used_q != CNT_W'(SLOTS)));
    // R10: a retirement only frees a slot that is held
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> (used_q != '0));
  end

endmodule

// File: rtl/wd_pick_simd.sv
module wd_pick_simd #(
  parameter int NUM_SIMD = 4,
  parameter int CNT_W    = 4,
  parameter int SEL_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SIMD-1:0][CNT_W-1:0] free_cnt,
  output logic                           pick_valid,
  output logic [SEL_W-1:0]               pick_sel
);

  always_comb begin
    pick_sel = '0;
    for (int i = 1; i < NUM_SIMD; i++) begin
      if (free_cnt[i] > free_cnt[pick_sel]) pick_sel = SEL_W'(i);
    end
  end

  assign pick_valid = (free_cnt[pick_sel] != '0);

  // Independent restatement of the choice for the checker.
  logic any_bigger;
  logic lower_tie;
  always_comb begin
    any_bigger = 1'b0;
    lower_tie  = 1'b0;
    for (int i = 0; i < NUM_SIMD; i++) begin
      if (free_cnt[i] > free_cnt[pick_sel]) any_bigger = 1'b1;
      if ((i < int'(pick_sel)) && (free_cnt[i] == free_cnt[pick_sel])) lower_tie = 1'b1;
    end
  end

  // R5: most free slots, lowest index on a tie
  assert_pick_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (!any_bigger && !lower_tie));

endmodule

// File: rtl/wd_req_seq.sv
module wd_req_seq
  import wd_pkg::*;
#(
  parameter int TC_W      = 16,
  parameter int PC_W      = 32,
  parameter int LANE_BITS = 6,
  parameter int WID_W     = 11,
  parameter int OUT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [PC_W-1:0]      req_pc,
  input  logic [TC_W-1:0]      req_threads,
  input  logic                 launch_fire,
  input  logic                 retire_valid,
  output logic                 req_ready,
  output logic                 want_launch,
  output logic [PC_W-1:0]      cur_pc,
  output logic [LANE_BITS-1:0] cur_tail,
  output logic [WID_W-1:0]     wave_idx,
  output logic [WID_W-1:0]     wave_total,
  output logic                 done
);

  wd_state_e            state_q;
  logic [PC_W-1:0]      pc_q;
  logic [LANE_BITS-1:0] tail_q;
  logic [WID_W-1:0]     total_q;
  logic [WID_W-1:0]     idx_q;
  logic [OUT_W-1:0]     out_q;
  logic                 done_q;

  logic req_fire;
  logic all_launched;
  logic finish;

  assign req_ready    = (state_q == WD_IDLE);
  assign req_fire     = req_valid && req_ready;
  assign all_launched = (idx_q == total_q);
  assign finish       = (state_q == WD_RUN) && all_launched && (out_q == '0);
  assign want_launch  = (state_q == WD_RUN) && !all_launched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      pc_q    <= '0;
      tail_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
      out_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (req_fire) begin
        state_q <= WD_RUN;
        pc_q    <= req_pc;
        tail_q  <= req_threads[LANE_BITS-1:0];
        total_q <= WID_W'(waves_for(32'(req_threads), LANE_BITS));
        idx_q   <= '0;
        out_q   <= '0;
      end else if (state_q == WD_RUN) begin
        if (launch_fire) idx_q <= idx_q + WID_W'(1);
        out_q <= out_q + OUT_W'(launch_fire) - OUT_W'(retire_valid);
        if (finish) state_q <= WD_IDLE;
      end
    end
  end

  assign cur_pc     = pc_q;
  assign cur_tail   = tail_q;
  assign wave_idx   = idx_q;
  assign wave_total = total_q;
  assign done       = done_q;

  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: done only after nothing is outstanding
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_q) == '0 && $past(state_q) == WD_RUN));
  // R2: wavefront indices advance by one per launch
  assert_wave_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |=> (idx_q == $past(idx_q) + WID_W'(1)));
  // R10: retirements only arrive for outstanding wavefronts
  assert_retire_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && state_q == WD_RUN) |-> (out_q != '0 || launch_fire));

endmodule

// File: rtl/wave_dispatch.sv
module wave_dispatch #(
  parameter int LANES    = 64,
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 10,
  parameter int TC_W     = 16,
  parameter int PC_W     = 32,
  localparam int LANE_BITS   = $clog2(LANES),
  localparam int SEL_W       = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int CNT_W       = $clog2(SLOTS + 1),
  localparam int TOTAL_SLOTS = NUM_SIMD * SLOTS,
  localparam int OUT_W       = $clog2(TOTAL_SLOTS + 1),
  localparam int WID_W       = TC_W - LANE_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [TC_W-1:0]   req_threads,
  output logic              launch_valid,
  output logic [SEL_W-1:0]  launch_simd,
  output logic [PC_W-1:0]   launch_pc,
  output logic [WID_W-1:0]  launch_wave,
  output logic [LANES-1:0]  launch_mask,
  input  logic              retire_valid,
  input  logic [SEL_W-1:0]  retire_simd,
  output logic              done
);

  // Lane mask: full except the last wavefront, which keeps the low tail lanes.
  function automatic logic [LANES-1:0] lanes_on(input logic [LANE_BITS-1:0] tail,
                                                input logic [WID_W-1:0]     idx,
                                                input logic [WID_W-1:0]     total);
    logic [LANES-1:0] m;
    if ((idx != total - WID_W'(1)) || (tail == '0)) return '1;
    for (int b = 0; b < LANES; b++) m[b] = (b < int'(tail));
    return m;
  endfunction

  logic                           want_launch;
  logic                           pick_valid;
  logic [SEL_W-1:0]               pick_sel;
  logic [NUM_SIMD-1:0][CNT_W-1:0] free_cnt;
  logic [PC_W-1:0]                cur_pc;
  logic [LANE_BITS-1:0]           cur_tail;
  logic [WID_W-1:0]               wave_idx;
  logic [WID_W-1:0]               wave_total;
  logic                           launch_fire;

  wd_req_seq #(
    .TC_W(TC_W), .PC_W(PC_W), .LANE_BITS(LANE_BITS), .WID_W(WID_W), .OUT_W(OUT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pc(req_pc), .req_threads(req_threads),
    .launch_fire(launch_fire), .retire_valid(retire_valid),
    .req_ready(req_ready), .want_launch(want_launch),
    .cur_pc(cur_pc), .cur_tail(cur_tail),
    .wave_idx(wave_idx), .wave_total(wave_total), .done(done)
  );

  wd_slot_ledger #(
    .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_ledger (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(launch_fire), .alloc_sel(pick_sel),
    .release_valid(retire_valid), .release_sel(retire_simd),
    .free_cnt(free_cnt)
  );

  wd_pick_simd #(
    .NUM_SIMD(NUM_SIMD), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n),
    .free_cnt(free_cnt), .pick_valid(pick_valid), .pick_sel(pick_sel)
  );

  assign launch_fire  = want_launch && pick_valid;
  assign launch_valid = launch_fire;
  assign launch_simd  = pick_sel;
  assign launch_pc    = cur_pc;
  assign launch_wave  = wave_idx;
  assign launch_mask  = lanes_on(cur_tail, wave_idx, wave_total);

  // R3: every launched wavefront has at least lane 0 enabled
  assert_mask_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> launch_mask[0]);
  // R4: the address stays fixed across back-to-back launches
  assert_pc_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && $past(launch_valid)) |-> $stable(launch_pc));
  // R1: no launch is offered while the block is idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !launch_valid);

endmodule

// File: tb/wave_dispatch_tb_top.sv
module wave_dispatch_tb_top;

  localparam int LANES = 64, NS = 4, SL = 2, TCW = 12, PCW = 32;
  localparam int SW = 2, WW = TCW - 6 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [PCW-1:0] req_pc = '0;
  logic [TCW-1:0] req_threads = '0;
  logic launch_valid;
  logic [SW-1:0] launch_simd;
  logic [PCW-1:0] launch_pc;
  logic [WW-1:0] launch_wave;
  logic [LANES-1:0] launch_mask;
  logic retire_valid = 1'b0;
  logic [SW-1:0] retire_simd = '0;
  logic done;

  always #4 clk = ~clk;

  wave_dispatch #(.LANES(LANES), .NUM_SIMD(NS), .SLOTS(SL), .TC_W(TCW), .PC_W(PCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_threads(req_threads), .launch_valid(launch_valid),
    .launch_simd(launch_simd), .launch_pc(launch_pc), .launch_wave(launch_wave),
    .launch_mask(launch_mask), .retire_valid(retire_valid), .retire_simd(retire_simd),
    .done(done));

  int checks = 0, fails = 0;
  int lcount = 0, dcount = 0;
  logic [SW-1:0]    r_simd [0:63];
  logic [PCW-1:0]   r_pc   [0:63];
  logic [WW-1:0]    r_wave [0:63];
  logic [LANES-1:0] r_mask [0:63];

  always @(negedge clk) begin
    if (rst_n && launch_valid && lcount < 64) begin
      r_simd[lcount] <= launch_simd; r_pc[lcount] <= launch_pc;
      r_wave[lcount] <= launch_wave; r_mask[lcount] <= launch_mask;
    end
    if (rst_n && launch_valid) lcount <= lcount + 1;
    if (rst_n && done) dcount <= dcount + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] low_bits(input int n);
    logic [63:0] m;
    for (int b = 0; b < 64; b++) m[b] = (b < n);
    return m;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [PCW-1:0] pc, input logic [TCW-1:0] thr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pc = pc; req_threads = thr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic retire(input logic [SW-1:0] s);
    retire_valid = 1'b1; retire_simd = s;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic wait_launch(input int n);
    for (int i = 0; i < 40 && lcount < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 40 && dcount < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    tick(1);
    check(req_ready === 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    check(launch_valid === 1'b0, "R1 reset launch", 64'(launch_valid), 64'd0);
    check(done === 1'b0, "R1 reset done", 64'(done), 64'd0);
  endtask

  task automatic t_half;
    int b = lcount, d = dcount;
    issue(32'h1000, 12'd32);
    wait_launch(b + 1); tick(3);
    check(lcount == b + 1, "R2 one wave for 32", 64'(lcount - b), 64'd1);
    check(r_mask[b] == low_bits(32), "R3 mask 32", r_mask[b], low_bits(32));
    check(r_simd[b] == 0 && r_wave[b] == 0, "R5 first simd/idx", {r_simd[b], r_wave[b]}, 64'd0);
    check(r_pc[b] == 32'h1000, "R4 pc", 64'(r_pc[b]), 64'h1000);
    check(dcount == d && req_ready == 1'b0, "R7 no early done", 64'(dcount - d), 64'd0);
    retire(r_simd[b]);
    wait_done(d + 1); tick(3);
    check(dcount == d + 1, "R7 single done pulse", 64'(dcount - d), 64'd1);
    check(req_ready === 1'b1, "R1 ready after done", 64'(req_ready), 64'd1);
  endtask

  task automatic t_96;
    int b = lcount, d = dcount;
    issue(32'h2000, 12'd96);
    wait_launch(b + 2); tick(2);
    check(lcount == b + 2, "R2 two waves for 96", 64'(lcount - b), 64'd2);
    check(r_mask[b] == '1 && r_mask[b+1] == low_bits(32), "R3 masks 96", r_mask[b+1], low_bits(32));
    check(r_simd[b] == 0 && r_simd[b+1] == 1, "R5 tie spread", {r_simd[b], r_simd[b+1]}, 64'h01);
    check(r_wave[b+1] == 1, "R2 index 1", 64'(r_wave[b+1]), 64'd1);
    retire(2'd1); retire(2'd0);
    wait_done(d + 1); tick(2);
    check(dcount == d + 1, "R7 done 96", 64'(dcount - d), 64'd1);
  endtask

  task automatic t_full;
    int b = lcount, d = dcount;
    bit ok;
    issue(32'h3000, 12'd600);
    wait_launch(b + 8); tick(4);
    check(lcount == b + 8, "R6 stall at full", 64'(lcount - b), 64'd8);
    ok = 1;
    for (int i = 0; i < 8; i++) ok &= (r_simd[b+i] == SW'(i % 4)) && (r_wave[b+i] == WW'(i));
    check(ok, "R5 round placement", 64'(r_simd[b+4]), 64'd0);
    check(req_ready === 1'b0, "R1 busy not ready", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_pc = 32'hDEAD; req_threads = 12'd5;
    tick(1); req_valid = 1'b0;
    retire(2'd2);
    wait_launch(b + 9); tick(1);
    check(r_simd[b+8] == 2 && r_mask[b+8] == '1, "R10 freed simd reused", 64'(r_simd[b+8]), 64'd2);
    check(r_pc[b+8] == 32'h3000, "R9 busy request ignored", 64'(r_pc[b+8]), 64'h3000);
    retire(2'd0);
    wait_launch(b + 10); tick(2);
    check(r_simd[b+9] == 0 && r_wave[b+9] == 9, "R5 last wave simd0", {r_simd[b+9], r_wave[b+9]}, 64'h09);
    check(r_mask[b+9] == low_bits(24), "R3 tail 24", r_mask[b+9], low_bits(24));
    check(lcount == b + 10, "R2 ten waves", 64'(lcount - b), 64'd10);
    for (int s = 0; s < 4; s++) retire(SW'(s));
    for (int s = 0; s < 3; s++) retire(SW'(s));
    tick(3);
    check(dcount == d, "R7 no done while one out", 64'(dcount - d), 64'd0);
    retire(2'd3);
    wait_done(d + 1); tick(3);
    check(dcount == d + 1, "R7 done after all retired", 64'(dcount - d), 64'd1);
    check(lcount == b + 10, "R9 no extra launches", 64'(lcount - b), 64'd10);
  endtask

  task automatic t_zero;
    int b = lcount, d = dcount;
    issue(32'h4000, 12'd0);
    check(done === 1'b0, "R8 not yet done", 64'(done), 64'd0);
    tick(1);
    check(done === 1'b1 && req_ready === 1'b1, "R8 done next cycle", {done, req_ready}, 64'h3);
    tick(1);
    check(done === 1'b0, "R7 pulse ends", 64'(done), 64'd0);
    check(lcount == b && dcount == d + 1, "R8 no launch", 64'(lcount - b), 64'd0);
  endtask

  task automatic t_exact;
    int b = lcount, d = dcount;
    issue(32'h5000, 12'd128);
    wait_launch(b + 2); tick(2);
    check(r_mask[b] == '1 && r_mask[b+1] == '1, "R3 exact multiple", r_mask[b+1], '1);
    check(r_pc[b+1] == 32'h5000, "R4 pc 128", 64'(r_pc[b+1]), 64'h5000);
    retire(2'd0); retire(2'd1);
    wait_done(d + 1); tick(2);
    check(dcount == d + 1, "R7 done 128", 64'(dcount - d), 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_half();
    t_96();
    t_full();
    t_zero();
    t_exact();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule